// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Responder

This block stands in for a small serial EEPROM of 16-bit words. A host controller under test drives the chip select, the serial clock and the data-in line, and the block answers on data-out. The serial lines are sampled by the block's own system clock, so the serial clock must be slower than that clock: each of its levels must last at least two system cycles.

While chip select is high, the block waits for a start bit of 1. It then takes a two-bit opcode and an address field, sent most significant bit first. Opcode 10 reads a word, 01 writes one and 11 erases one. Opcode 00 is a family of four commands picked by the two top address bits: enable programming, disable programming, fill every word with ones, or fill every word with a data word. Every programming command is gated by an enable latch. The word array keeps its contents across reset, while the enable latch does not. The address field is 6 bits wide by default and may be set to 8.

Top module: `uw_eeprom_model`

## Requirements
- R1: After reset, `sdo_o` is 0 and the programming enable latch is clear, so a WRITE issued before any enable command leaves the addressed word unchanged.
- R2: While chip select is high, data-in bits of 0 that come before the start bit of 1 are ignored. After the start bit come 2 opcode bits and then ADDR_W address bits, all most significant bit first and all sampled on rising serial-clock edges.
- R3: READ (opcode 10): on the rising edge that carries the last address bit, `sdo_o` becomes a dummy 0. Each of the next 16 rising edges moves `sdo_o` to the next bit of the addressed word, bit 15 first.
- R4: WRITE (opcode 01), with the enable latch set, stores the 16 data bits that follow the address (bit 15 first) at the addressed word.
- R5: ERASE (opcode 11), with the enable latch set, sets the addressed word to 16'hFFFF.
- R6: Opcode 00 with the address top bits equal to 11 sets the enable latch, and with top bits 00 clears it. The other address bits have no effect.
- R7: Opcode 00 with address top bits 10, with the enable latch set, sets every word to 16'hFFFF.
- R8: Opcode 00 with address top bits 01, with the enable latch set, writes the 16 data bits that follow to every word.
- R9: While the enable latch is clear, WRITE, ERASE and both fill commands leave the array unchanged.
- R10: Chip select going low at any point abandons the current instruction. A partly shifted write changes nothing, and the next instruction is decoded from a fresh start bit.
- R11: The word array keeps its contents through an assertion of `rst_ni`.
- R12: `sdo_o` is 0 in the cycle after any cycle in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial lines are sampled on it |
| rst_ni | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The bench goes after the timing of the dummy bit. A design that skipped it, or counted one edge too many, would return the word shifted by one place. It checks that the don't-care address bits of the opcode 00 family are really ignored; a decoder that used them would miss the enable or disable. It aborts a write in mid-data and a read in mid-address. A design that committed partial data, or failed to resync on the next start bit, would corrupt a word or return garbage. It also issues programming commands after a disable and after a reset. A missing latch gate would show as an overwritten word, and a word array that clears on reset would lose data written before it.

// File: rtl/uw_eeprom_pkg.sv
package uw_eeprom_pkg;

  typedef enum logic [2:0] {
    CMD_READ,
    CMD_WRITE,
    CMD_ERASE,
    CMD_PROG_ON,
    CMD_PROG_OFF,
    CMD_FILL_ONES,
    CMD_FILL_DATA
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_RD,
    PH_HOLD
  } phase_e;

  // opcode plus the two top address bits pick the command
  function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] top);
    cmd_e c;
    case (opc)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        case (top)
          2'b11:   c = CMD_PROG_ON;
          2'b10:   c = CMD_FILL_ONES;
          2'b01:   c = CMD_FILL_DATA;
          default: c = CMD_PROG_OFF;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic takes_data(input cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_FILL_DATA);
  endfunction

endpackage

// File: rtl/uw_sclk_edge.sv
module uw_sclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;

endmodule

// File: rtl/uw_word_array.sv
module uw_word_array #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_one_i,
  input  logic              wr_all_i,
  input  logic              ones_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];
  logic [WORD_W-1:0] wdata;

  assign wdata = ones_i ? {WORD_W{1'b1}} : wr_data_i;

  // no reset on purpose: contents survive rst_ni
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic              hit;
    logic [WORD_W-1:0] cell_q;
    assign hit = wr_all_i | (wr_one_i && (wr_idx_i == ADDR_W'(g)));
    always_ff @(posedge clk_i) begin
      if (hit) cell_q <= wdata;
    end
    assign cells[g] = cell_q;
  end

  assign rd_word_o = cells[rd_idx_i];

  AST_ERASE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_one_i && ones_i) |=> (cells[$past(wr_idx_i)] == {WORD_W{1'b1}})); // R5
  AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_one_i && !ones_i) |=> (cells[$past(wr_idx_i)] == $past(wr_data_i))); // R4
  AST_FILL_REACHES_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_all_i && ones_i) |=> (cells[0] == {WORD_W{1'b1}} && cells[DEPTH-1] == {WORD_W{1'b1}})); // R7

endmodule

// File: rtl/uw_decoder.sv
module uw_decoder
  import uw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  input  logic              prog_en_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] rd_idx_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_one_o,
  output logic              wr_all_o,
  output logic              ones_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  phase_e            phase_q;
  cmd_e              cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] adr_q;
  logic [WORD_W-1:0] din_q;
  logic [WORD_W-1:0] dout_q;
  logic              sdo_q;

  // named events for assertions
  logic              step;
  logic              adr_done;
  logic              dat_done;
  logic [ADDR_W-1:0] adr_nx;
  logic [WORD_W-1:0] din_nx;
  logic [1:0]        opc_nx;
  cmd_e              cmd_now;
  logic              erase_one, erase_all, write_one, write_all;

  assign step     = cs_i & rise_i;
  assign adr_nx   = {adr_q[ADDR_W-2:0], sdi_i};
  assign din_nx   = {din_q[WORD_W-2:0], sdi_i};
  assign opc_nx   = {opc_q[0], sdi_i};
  assign adr_done = step && (phase_q == PH_ADR) && (cnt_q == CNT_W'(ADDR_W - 1));
  assign dat_done = step && (phase_q == PH_DAT) && (cnt_q == CNT_W'(WORD_W - 1));
  assign cmd_now  = decode_cmd(opc_q, adr_nx[ADDR_W-1 -: 2]);

  assign erase_one = adr_done && (cmd_now == CMD_ERASE)     && prog_en_i;
  assign erase_all = adr_done && (cmd_now == CMD_FILL_ONES) && prog_en_i;
  assign write_one = dat_done && (cmd_q == CMD_WRITE)       && prog_en_i;
  assign write_all = dat_done && (cmd_q == CMD_FILL_DATA)   && prog_en_i;

  assign en_set_o  = adr_done && (cmd_now == CMD_PROG_ON);
  assign en_clr_o  = adr_done && (cmd_now == CMD_PROG_OFF);
  assign wr_one_o  = erase_one | write_one;
  assign wr_all_o  = erase_all | write_all;
  assign ones_o    = erase_one | erase_all;
  assign wr_idx_o  = adr_done ? adr_nx : adr_q;
  assign wr_data_o = din_nx;
  assign rd_idx_o  = adr_nx;
  assign sdo_o     = sdo_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cmd_q   <= CMD_PROG_OFF;
      cnt_q   <= '0;
      opc_q   <= '0;
      adr_q   <= '0;
      din_q   <= '0;
      dout_q  <= '0;
      sdo_q   <= 1'b0;
    end else if (!cs_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sdo_q   <= 1'b0;
    end else if (rise_i) begin
      case (phase_q)
        PH_IDLE: begin
          if (sdi_i) begin
            phase_q <= PH_OPC;
            cnt_q   <= '0;
          end
        end
        PH_OPC: begin
          opc_q <= opc_nx;
          if (cnt_q == CNT_W'(1)) begin
            phase_q <= PH_ADR;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_ADR: begin
          adr_q <= adr_nx;
          if (adr_done) begin
            cnt_q <= '0;
            cmd_q <= cmd_now;
            if (cmd_now == CMD_READ) begin
              dout_q  <= rd_word_i;
              sdo_q   <= 1'b0;
              phase_q <= PH_RD;
            end else if (takes_data(cmd_now)) begin
              phase_q <= PH_DAT;
            end else begin
              phase_q <= PH_HOLD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DAT: begin
          din_q <= din_nx;
          if (dat_done) phase_q <= PH_HOLD;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        PH_RD: begin
          if (cnt_q == CNT_W'(WORD_W)) begin
            sdo_q   <= 1'b0;
            phase_q <= PH_HOLD;
          end else begin
            sdo_q  <= dout_q[WORD_W-1];
            dout_q <= {dout_q[WORD_W-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (phase_q == PH_IDLE)); // R10
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_one_o, wr_all_o, en_set_o, en_clr_o})); // R6
  AST_READ_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adr_done && cmd_now == CMD_READ) |=> (!sdo_q && phase_q == PH_RD)); // R3
  AST_IDLE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && phase_q == PH_IDLE && !sdi_i) |=> (phase_q == PH_IDLE)); // R2

endmodule

// File: rtl/uw_eeprom_model.sv
module uw_eeprom_model #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic              rise;
  logic              prog_en_q;
  logic              en_set, en_clr;
  logic              wr_one, wr_all, ones;
  logic [ADDR_W-1:0] rd_idx, wr_idx;
  logic [WORD_W-1:0] wr_data, rd_word;

  uw_sclk_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (rise)
  );

  uw_decoder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .rise_i    (rise),
    .sdi_i     (sdi_i),
    .prog_en_i (prog_en_q),
    .rd_word_i (rd_word),
    .rd_idx_o  (rd_idx),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .wr_one_o  (wr_one),
    .wr_all_o  (wr_all),
    .ones_o    (ones),
    .en_set_o  (en_set),
    .en_clr_o  (en_clr),
    .sdo_o     (sdo_o)
  );

  uw_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_one_i  (wr_one),
    .wr_all_i  (wr_all),
    .ones_i    (ones),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_word_o (rd_word)
  );

  // programming enable latch
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     prog_en_q <= 1'b0;
    else if (en_set) prog_en_q <= 1'b1;
    else if (en_clr) prog_en_q <= 1'b0;
  end

  AST_SDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !sdo_o); // R12
  AST_EN_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set |=> prog_en_q); // R6
  AST_EN_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr |=> !prog_en_q); // R6
  AST_PROG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_one || wr_all) |-> prog_en_q); // R9

endmodule

// File: tb/uw_eeprom_model_test.sv
module uw_eeprom_model_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;

  uw_eeprom_model #(.ADDR_W(AW), .WORD_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit model_en = 0;
  logic [15:0] model [1<<AW];
  logic [15:0] exp_w[$];
  string       exp_tag[$];
  logic [15:0] got_w[$];

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    @(negedge clk);
    sclk = 1'b0; sdi = b;
    wait_n(HALF);
    sclk = 1'b1;
    wait_n(2);
    s = sdo;
    wait_n(1);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_n(2);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_n(3);
  endtask

  task automatic send_head(input logic [1:0] op, input logic [AW-1:0] a, output logic s);
    clk_bit(1'b1, s);
    clk_bit(op[1], s);
    clk_bit(op[0], s);
    for (int i = AW-1; i >= 0; i--) clk_bit(a[i], s);
  endtask

  task automatic send_word(input logic [15:0] d);
    logic s;
    for (int i = 15; i >= 0; i--) clk_bit(d[i], s);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
    logic s;
    cs_on(); send_head(2'b01, a, s); send_word(d); cs_off();
    if (model_en) model[a] = d;
  endtask

  task automatic do_erase(input logic [AW-1:0] a);
    logic s;
    cs_on(); send_head(2'b11, a, s); cs_off();
    if (model_en) model[a] = 16'hFFFF;
  endtask

  task automatic do_prog_on(input logic [AW-1:0] a);
    logic s;
    cs_on(); send_head(2'b00, a, s); cs_off();
    model_en = 1;
  endtask

  task automatic do_prog_off(input logic [AW-1:0] a);
    logic s;
    cs_on(); send_head(2'b00, a, s); cs_off();
    model_en = 0;
  endtask

  task automatic do_fill_ones();
    logic s;
    cs_on(); send_head(2'b00, 6'b101101, s); cs_off();
    if (model_en) for (int i = 0; i < (1<<AW); i++) model[i] = 16'hFFFF;
  endtask

  task automatic do_fill_data(input logic [15:0] d);
    logic s;
    cs_on(); send_head(2'b00, 6'b010110, s); send_word(d); cs_off();
    if (model_en) for (int i = 0; i < (1<<AW); i++) model[i] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag, input int lead);
    logic s;
    logic [15:0] w;
    cs_on();
    for (int i = 0; i < lead; i++) clk_bit(1'b0, s);
    send_head(2'b10, a, s);
    check(s == 1'b0, "R3 dummy bit", {15'd0, s}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0, s);
      w[i] = s;
    end
    exp_w.push_back(model[a]);
    exp_tag.push_back(tag);
    got_w.push_back(w);
    cs_off();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    model_en = 0;
  endtask

  // monitor: compares each returned word with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (got_w.size() > 0) begin
        logic [15:0] g, e;
        string t;
        g = got_w.pop_front();
        e = exp_w.pop_front();
        t = exp_tag.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    wait_n(4);
    do_reset();
    check(sdo == 1'b0, "R1 sdo after reset", {15'd0, sdo}, 16'd0);
    cs_on();
    check(sdo == 1'b0, "R1 sdo idle selected", {15'd0, sdo}, 16'd0);
    cs_off();

    // known contents
    do_prog_on(6'b110000);
    do_fill_data(16'h0000);
    do_read(6'd0,  "R8 fill zero low", 0);
    do_read(6'd63, "R8 fill zero high", 0);

    // contents survive reset; latch does not
    do_write(6'd7, 16'hBEEF);
    do_reset();
    do_write(6'd5, 16'hA5A5);
    do_read(6'd7, "R11 word kept across reset", 0);
    do_read(6'd5, "R1 write ignored after reset", 0);

    // enable with other don't-care bits, then writes
    do_prog_on(6'b111010);
    do_write(6'd5, 16'h1234);
    do_write(6'd62, 16'h8001);
    do_read(6'd5, "R4 write", 0);
    do_read(6'd62, "R4 write high addr", 3);
    do_read(6'd62, "R2 leading zeros", 7);

    do_erase(6'd5);
    do_read(6'd5, "R5 erase", 0);

    // disable gates programming
    do_prog_off(6'b001101);
    do_write(6'd6, 16'h5555);
    do_erase(6'd62);
    do_fill_ones();
    do_read(6'd6, "R9 write blocked", 0);
    do_read(6'd62, "R9 erase blocked", 0);
    do_read(6'd0, "R6 disable with dont-care bits", 0);

    // aborted write
    do_prog_on(6'b110111);
    cs_on(); send_head(2'b01, 6'd9, s);
    for (int i = 0; i < 8; i++) clk_bit(1'b1, s);
    cs_off();
    do_read(6'd9, "R10 aborted write", 0);
    // aborted read, then a clean read
    cs_on(); clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    cs_off();
    do_read(6'd62, "R10 resync after abort", 0);

    do_fill_ones();
    do_read(6'd0,  "R7 fill ones low", 0);
    do_read(6'd33, "R7 fill ones mid", 0);

    do_fill_data(16'hC3C3);
    do_read(6'd10, "R8 fill data", 0);
    do_read(6'd63, "R8 fill data high", 0);
    check(sdo == 1'b0, "R12 sdo low after deselect", {15'd0, sdo}, 16'd0);

    // selected read ending on a 1, then deselect mid-stream
    cs_on(); send_head(2'b10, 6'd63, s);
    for (int i = 0; i < 16; i++) clk_bit(1'b0, s);
    check(s == 1'b1, "R3 last data bit", {15'd0, s}, 16'd1);
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    check(sdo == 1'b0, "R12 sdo cleared on deselect", {15'd0, sdo}, 16'd0);
    wait_n(3);

    while (got_w.size() > 0) @(negedge clk);
    wait_n(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule